// File: doc/BRIEF.md
# Scanning Request Arbiter

The arbiter shares one service resource among a set of request lines, such as interrupt or DMA requests, without a priority encoder. A pointer walks the inputs in a fixed cyclic order and stays on each one for a fixed number of clock cycles. If the input under the pointer is requesting when its dwell interval ends, that input receives the grant and the pointer stops. It stays stopped until the requester reports completion or withdraws its request. The same structure serves interrupt lines and DMA lines alike. No input outranks another, so service approximates round-robin and, roughly, first come first served.

Request lines may come from other clock domains. Each one passes through a two-stage synchronizer before the scanner looks at it. Because the pointer never skips ahead, the wait from a request rising to its grant has a fixed upper bound set by the input count and the dwell length. With the defaults (8 inputs, 12 cycles per input, 5 ns clock) the scan round is 480 ns.

Top module: `scan_arbiter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, gnt_o is all zero, gnt_valid_o is 0 and gnt_idx_o is 0.
- R2: A change on req_i reaches the scanner after two rising clock edges, through a two-flop synchronizer on each line. Only that delayed copy of the request is used.
- R3: While no grant is active, the pointer (gnt_idx_o) stays on each input for exactly DWELL_CYC cycles. It then advances by one, wrapping from NUM_REQ-1 to 0.
- R4: If the synchronized request of the input under the pointer is high in the last cycle of its dwell, then from the next cycle gnt_valid_o is 1, gnt_o has only bit gnt_idx_o set, and the pointer stops.
- R5: A grant, with its index, is held for as long as the served request stays high and done_i stays low.
- R6: done_i high for one cycle during a grant ends the grant in the next cycle. The pointer then moves to the next input in cyclic order, not to input 0, and a fresh dwell starts there.
- R7: If the synchronized request of the served input falls during a grant, the grant ends in the next cycle and the pointer moves to the next input.
- R8: An input whose request is low at the end of its dwell gets no grant, even if it pulsed while the pointer was elsewhere.
- R9: No input has fixed priority. When every input requests continuously, grants go to consecutive indices in cyclic order.
- R10: When no other input is requesting, a request held high is granted within NUM_REQ*DWELL_CYC+3 cycles of its rising edge.
- R11: gnt_o is always zero or one-hot. It is non-zero exactly when gnt_valid_o is 1, and its set bit is at gnt_idx_o.
- R12: done_i has no effect while no grant is active. The scan continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Request lines, may be asynchronous |
| done_i | input | 1 | Completion pulse from the served requester |
| gnt_o | output | NUM_REQ | One-hot grant |
| gnt_valid_o | output | 1 | A grant is active |
| gnt_idx_o | output | $clog2(NUM_REQ) | Input under the pointer (the served input while granting) |

## Verification
The bench targets the moment a dwell expires. A dwell counter that is off by one shifts every later pointer step and shows up as an index mismatch against the bench's cycle model. One test pulses a request while the pointer is on a different input. A design that latched requests instead of sampling them would grant that input later, when it should skip it. With all inputs requesting, a design that resumed from input 0 after each release would break the cyclic grant order. A design that let done_i act outside a grant would lose its place in the scan. A random phase with short request pulses and stray done pulses checks the two-cycle synchronizer delay and releases caused by a request dropping, cycle by cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_HOLD = 1'b1
  } scan_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        sync_q <= meta_q;
      end
    end
    assign sync_o[b] = sync_q;
  end
endmodule

// File: rtl/arb_dwell.sv
module arb_dwell #(
  parameter int DWELL_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R3: a stopped scan restarts its dwell from zero
  a_r3_dwell_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  a_r3_dwell_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/arb_scan.sv
module arb_scan
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               expire_i,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               done_i,
  output logic               hold_o,
  output logic [IDX_W-1:0]   ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REQ - 1);

  scan_state_e      state_q;
  logic [IDX_W-1:0] ptr_q, ptr_nxt;
  logic             cur_req;

  assign cur_req = req_i[ptr_q];
  assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SCAN: if (expire_i) begin
          if (cur_req) state_q <= ST_HOLD;
          else         ptr_q   <= ptr_nxt;
        end
        ST_HOLD: if (done_i || !cur_req) begin
          state_q <= ST_SCAN;
          ptr_q   <= ptr_nxt;
        end
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  assign hold_o = (state_q == ST_HOLD);
  assign ptr_o  = ptr_q;

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q != $past(ptr_q) |-> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
  a_r4_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o && expire_i && cur_req |=> hold_o && $stable(ptr_q));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && !done_i && cur_req |=> hold_o && $stable(ptr_q));
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && done_i |=> !hold_o);
  a_r7_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && !cur_req |=> !hold_o);
  a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o && !expire_i |=> $stable(ptr_q));
endmodule

// File: rtl/scan_arbiter.sv
module scan_arbiter #(
  parameter int NUM_REQ   = 8,
  parameter int DWELL_CYC = 12,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               done_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               gnt_valid_o,
  output logic [IDX_W-1:0]   gnt_idx_o
);
  logic [NUM_REQ-1:0] req_sync;
  logic               expire, hold;
  logic [IDX_W-1:0]   ptr;

  arb_sync #(.WIDTH(NUM_REQ)) i_sync (
    .clk_i, .rst_ni, .async_i(req_i), .sync_o(req_sync)
  );

  arb_dwell #(.DWELL_CYC(DWELL_CYC)) i_dwell (
    .clk_i, .rst_ni, .run_i(!hold), .expire_o(expire)
  );

  arb_scan #(.NUM_REQ(NUM_REQ)) i_scan (
    .clk_i, .rst_ni, .expire_i(expire), .req_i(req_sync),
    .done_i, .hold_o(hold), .ptr_o(ptr)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_gnt
    assign gnt_o[i] = hold && (ptr == IDX_W'(i));
  end

  assign gnt_valid_o = hold;
  assign gnt_idx_o   = ptr;

  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != '0)));
  a_r11_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> gnt_o[gnt_idx_o]);
endmodule

// File: tb/test_scan_arbiter.sv
module test_scan_arbiter;
  localparam int N = 8;
  localparam int D = 12;
  localparam int IW = $clog2(N);
  localparam int BOUND = N * D + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] req_r = '0;
  logic done_r = 1'b0;
  logic [N-1:0] gnt_o;
  logic gnt_valid_o;
  logic [IW-1:0] gnt_idx_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_en = 0;
  string cur_tag = "R3";

  always #2.5 clk = ~clk;

  scan_arbiter #(.NUM_REQ(N), .DWELL_CYC(D)) i_scan_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_r), .done_i(done_r),
    .gnt_o(gnt_o), .gnt_valid_o(gnt_valid_o), .gnt_idx_o(gnt_idx_o)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // cycle model built from the requirements
  logic [N-1:0] m_s1, m_s2;
  int m_ptr, m_cnt;
  bit m_hold;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = '0; m_s2 = '0; m_ptr = 0; m_cnt = 0; m_hold = 0;
    end else begin
      if (m_hold) begin
        if (done_r || !m_s2[m_ptr]) begin
          m_hold = 0; m_ptr = (m_ptr + 1) % N; m_cnt = 0;
        end
      end else if (m_cnt == D - 1) begin
        m_cnt = 0;
        if (m_s2[m_ptr]) m_hold = 1;
        else m_ptr = (m_ptr + 1) % N;
      end else m_cnt++;
      m_s2 = m_s1; m_s1 = req_r;
    end
  end

  function automatic logic [N-1:0] exp_gnt(bit h, int p);
    return h ? (N'(1) << p) : '0;
  endfunction

  always @(negedge clk) if (chk_en) begin
    check(gnt_valid_o == m_hold, cur_tag, "gnt_valid_o", gnt_valid_o, m_hold);
    check(int'(gnt_idx_o) == m_ptr, cur_tag, "gnt_idx_o", gnt_idx_o, m_ptr);
    check(gnt_o == exp_gnt(m_hold, m_ptr), "R11", "gnt_o", gnt_o, exp_gnt(m_hold, m_ptr));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_grant(output int w);
    w = 0;
    do begin @(negedge clk); w++; end while (!gnt_valid_o && w <= BOUND + 5);
  endtask

  initial begin
    int w, prev;
    bit seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(gnt_o == '0 && !gnt_valid_o && gnt_idx_o == '0, "R1", "outputs in reset",
          {gnt_valid_o, gnt_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(gnt_o == '0 && !gnt_valid_o && gnt_idx_o == '0, "R1", "outputs after reset",
          {gnt_valid_o, gnt_o}, 0);
    chk_en = 1;

    // R3: idle scan, model comparison covers dwell length and wrap
    cur_tag = "R3";
    repeat (2 * N * D + 5) @(negedge clk);

    // R10 latency, then R5 hold and R7 release by drop
    cur_tag = "R10";
    req_r[5] = 1'b1;
    wait_grant(w);
    check(w <= BOUND, "R10", "grant latency", w, BOUND);
    check(gnt_idx_o == 3'd5, "R10", "granted index", gnt_idx_o, 5);
    cur_tag = "R5";
    repeat (40) @(negedge clk);
    check(gnt_valid_o && gnt_idx_o == 3'd5, "R5", "grant held", gnt_idx_o, 5);
    cur_tag = "R7";
    req_r[5] = 1'b0;
    repeat (3) @(negedge clk);
    check(!gnt_valid_o && gnt_idx_o == 3'd6, "R7", "release on drop, idx", gnt_idx_o, 6);

    // R8: pulse input 3 while pointer sits on 6
    cur_tag = "R8";
    while (gnt_idx_o != 3'd6) @(negedge clk);
    req_r[3] = 1'b1;
    @(negedge clk);
    req_r[3] = 1'b0;
    seen = 0;
    while (gnt_idx_o != 3'd4) begin @(negedge clk); seen |= gnt_valid_o; end
    check(!seen, "R8", "no grant for stale pulse", seen, 0);

    // R9 cyclic order, R6 release by done
    cur_tag = "R9";
    req_r = '1;
    prev = -1;
    for (int k = 0; k < 10; k++) begin
      wait_grant(w);
      check(w <= BOUND, "R9", "grant arrives", w, BOUND);
      if (prev >= 0)
        check(int'(gnt_idx_o) == (prev + 1) % N, "R9", "cyclic order", gnt_idx_o, (prev + 1) % N);
      prev = gnt_idx_o;
      done_r = 1'b1;
      @(negedge clk);
      done_r = 1'b0;
      check(!gnt_valid_o && int'(gnt_idx_o) == (prev + 1) % N, "R6", "release on done",
            gnt_idx_o, (prev + 1) % N);
    end

    // R2: random short pulses and stray done, checked cycle by cycle
    cur_tag = "R2";
    req_r = '0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      for (int b = 0; b < N; b++) if ($urandom_range(31) == 0) req_r[b] = ~req_r[b];
      done_r = ($urandom_range(15) == 0);
    end
    done_r = 1'b0;

    // R12: done while idle leaves the scan untouched
    cur_tag = "R12";
    req_r = '0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      done_r = 1'b1;
      @(negedge clk);
      done_r = 1'b0;
      @(negedge clk);
    end
    check(!gnt_valid_o, "R12", "no grant from idle done", gnt_valid_o, 0);

    chk_en = 0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule